// File: doc/BRIEF.md
# Function-Coded Integer ALU

A 32-bit integer arithmetic and logic unit for a small three-operand processor. A 4-bit function code selects one of add, subtract, multiply, divide, AND, OR, XOR, shift left, logical shift right, arithmetic shift right or rotate left. A separate 5-bit major opcode selects the source of the second operand. In register form it is a 32-bit register value. In immediate form it is a 17-bit constant, sign-extended to 32 bits. The same function codes serve both forms.

The first operand and the chosen second operand are computed on combinationally. A parameter adds a registered output stage, and that stage is on by default. Two flags report a zero divisor and an unknown function or opcode. Fetch, register-file and memory access are outside this block.

Top module: `fcalu`

## Requirements
- R1: With opcode 5'b00001, the second operand is `b_i`. Function 4'b0000 returns `a_i + b_i` and 4'b0001 returns `a_i - b_i`, both modulo 2^32 in two's complement.
- R2: With opcode 5'b00010, the second operand is `imm_i` sign-extended from bit 16, and `b_i` is ignored. Adding a negative immediate therefore subtracts.
- R3: Function 4'b0010 returns the low 32 bits of the signed product.
- R4: Function 4'b0011 returns the signed quotient truncated toward zero. 32'h8000_0000 divided by 32'hFFFF_FFFF returns 32'h8000_0000.
- R5: A divide with a zero second operand returns 32'hFFFF_FFFF and raises `div_zero_o`. No other case raises `div_zero_o`.
- R6: Functions 4'b0100, 4'b0101 and 4'b0110 return bitwise AND, OR and XOR.
- R7: Function 4'b1000 shifts left and 4'b1010 shifts right with zero fill. The count is bits [4:0] of the second operand.
- R8: Function 4'b1011 shifts right, filling the vacated bits with the original bit 31.
- R9: Function 4'b1001 rotates left by bits [4:0] of the second operand. A count of 0 returns `a_i` unchanged.
- R10: Function codes 4'b0111 and 4'b1100 to 4'b1111, or any opcode other than 1 or 2, return zero with `illegal_o` high and `div_zero_o` low.
- R11: With OUT_REG=1, the result and flags change only at the rising clock edge that samples the inputs. While `rst_ni` is low they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opc_i | input | 5 | Major opcode: 1 register form, 2 immediate form |
| func_i | input | 4 | Function code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Register second operand |
| imm_i | input | 17 | Immediate second operand, signed |
| result_o | output | 32 | Result |
| div_zero_o | output | 1 | Divide by zero |
| illegal_o | output | 1 | Unknown function code or opcode |

## Verification
The bench targets signed division at its edges: mixed signs, the most negative dividend over minus one, and a zero divisor in both forms. A design that floors instead of truncating returns -4 for -7/2. A design that traps or wraps on the overflow case gives a wrong quotient. A design with no divisor guard returns an unknown value and no flag.

Immediate handling is checked with bit 16 set and clear, while `b_i` holds a decoy value. This exposes zero extension and a wrong operand mux. Shift counts are given with upper bits set, and rotate is tried with a count of 0. A design that uses the full operand as the count, or forms the rotate from a 32-bit shift, clears or corrupts the result. Unused function codes and opcodes must give zero and the illegal flag.

// File: rtl/fcalu_pkg.sv
package fcalu_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'b0000,
    FN_SUB = 4'b0001,
    FN_MUL = 4'b0010,
    FN_DIV = 4'b0011,
    FN_AND = 4'b0100,
    FN_OR  = 4'b0101,
    FN_XOR = 4'b0110,
    FN_SLL = 4'b1000,
    FN_ROL = 4'b1001,
    FN_SRL = 4'b1010,
    FN_SRA = 4'b1011
  } func_e;

  localparam logic [4:0] OPC_REG = 5'd1;
  localparam logic [4:0] OPC_IMM = 5'd2;
endpackage

// File: rtl/fcalu_opsel.sv
module fcalu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 17
) (
  input  logic [4:0]        opc_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_o,
  output logic              opc_ok_o
);
  import fcalu_pkg::*;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    opc_ok_o = 1'b1;
    opnd_o   = b_i;
    if (opc_i == OPC_IMM)      opnd_o = imm_ext;
    else if (opc_i != OPC_REG) opc_ok_o = 1'b0;
  end
endmodule

// File: rtl/fcalu_arith.sv
module fcalu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel_i,   // func[1:0]: add, sub, mul, div
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              dz_o
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic              b_zero, ovf;
  logic [DATA_W-1:0] b_safe, quot;

  assign b_zero = (b_i == '0);
  assign ovf    = (a_i == MIN_NEG) && (b_i == '1);
  // keep the divider away from the undefined operand pairs
  assign b_safe = (b_zero || ovf) ? {{(DATA_W-1){1'b0}}, 1'b1} : b_i;
  assign quot   = $signed(a_i) / $signed(b_safe);

  always_comb begin
    dz_o = 1'b0;
    unique case (sel_i)
      2'd0: y_o = a_i + b_i;
      2'd1: y_o = a_i - b_i;
      2'd2: y_o = a_i * b_i;
      default: begin
        if (b_zero) begin
          y_o  = '1;
          dz_o = 1'b1;
        end else if (ovf) begin
          y_o = MIN_NEG;
        end else begin
          y_o = quot;
        end
      end
    endcase
  end
endmodule

// File: rtl/fcalu_shift.sv
module fcalu_shift #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [1:0]        sel_i,   // func[1:0]: sll, rol, srl, sra
  input  logic [DATA_W-1:0] a_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] y_o
);
  logic [2*DATA_W-1:0] dbl;
  assign dbl = {a_i, a_i} << amt_i;

  always_comb begin
    unique case (sel_i)
      2'd0: y_o = a_i << amt_i;
      2'd1: y_o = dbl[2*DATA_W-1:DATA_W];
      2'd2: y_o = a_i >> amt_i;
      default: y_o = $signed(a_i) >>> amt_i;
    endcase
  end
endmodule

// File: rtl/fcalu.sv
module fcalu #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 17,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        opc_i,
  input  logic [3:0]        func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              div_zero_o,
  output logic              illegal_o
);
  import fcalu_pkg::*;
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] opnd, ar_y, sh_y, res_d;
  logic              opc_ok, ar_dz, dz_d, ill_d;

  fcalu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .opc_i, .b_i, .imm_i, .opnd_o(opnd), .opc_ok_o(opc_ok)
  );

  fcalu_arith #(.DATA_W(DATA_W)) u_arith (
    .sel_i(func_i[1:0]), .a_i, .b_i(opnd), .y_o(ar_y), .dz_o(ar_dz)
  );

  fcalu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .sel_i(func_i[1:0]), .a_i, .amt_i(opnd[AMT_W-1:0]), .y_o(sh_y)
  );

  always_comb begin
    res_d = '0;
    dz_d  = 1'b0;
    ill_d = 1'b0;
    case (func_e'(func_i))
      FN_ADD, FN_SUB, FN_MUL, FN_DIV: begin
        res_d = ar_y;
        dz_d  = ar_dz;
      end
      FN_AND: res_d = a_i & opnd;
      FN_OR:  res_d = a_i | opnd;
      FN_XOR: res_d = a_i ^ opnd;
      FN_SLL, FN_ROL, FN_SRL, FN_SRA: res_d = sh_y;
      default: ill_d = 1'b1;
    endcase
    if (!opc_ok) ill_d = 1'b1;
    if (ill_d) begin
      res_d = '0;
      dz_d  = 1'b0;
    end
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o   <= '0;
        div_zero_o <= 1'b0;
        illegal_o  <= 1'b0;
      end else begin
        result_o   <= res_d;
        div_zero_o <= dz_d;
        illegal_o  <= ill_d;
      end
    end
  end else begin : g_comb
    assign result_o   = res_d;
    assign div_zero_o = dz_d;
    assign illegal_o  = ill_d;
  end
endmodule

// File: rtl/fcalu_chk.sv
module fcalu_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 17,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        opc_i,
  input logic [3:0]        func_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              div_zero_o,
  input logic              illegal_o
);
  logic [4:0]        q_opc;
  logic [3:0]        q_fn;
  logic [DATA_W-1:0] q_a, q_b;
  logic [IMM_W-1:0]  q_imm;

  if (OUT_REG) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_opc <= '0; q_fn <= '0; q_a <= '0; q_b <= '0; q_imm <= '0;
      end else begin
        q_opc <= opc_i; q_fn <= func_i; q_a <= a_i; q_b <= b_i; q_imm <= imm_i;
      end
    end
  end else begin : g_pass
    assign q_opc = opc_i;
    assign q_fn  = func_i;
    assign q_a   = a_i;
    assign q_b   = b_i;
    assign q_imm = imm_i;
  end

  p_add_reg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_opc == 5'd1 && q_fn == 4'b0000) |-> (result_o == q_a + q_b));

  p_imm_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_opc == 5'd2 && q_fn == 4'b0000) |->
      (result_o == q_a + {{(DATA_W-IMM_W){q_imm[IMM_W-1]}}, q_imm}));

  p_div_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> (result_o == '1 && !illegal_o && q_fn == 4'b0011));

  p_xor_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_opc == 5'd1 && q_fn == 4'b0110) |-> (result_o == (q_a ^ q_b)));

  p_illegal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0 && !div_zero_o));
endmodule

bind fcalu fcalu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/fcalu_tb.sv
module fcalu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  opc_i = '0;
  logic [3:0]  func_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [16:0] imm_i = '0;
  logic [31:0] result_o;
  logic        div_zero_o, illegal_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fcalu u_dut (.clk_i(clk), .rst_ni, .opc_i, .func_i, .a_i, .b_i, .imm_i,
               .result_o, .div_zero_o, .illegal_o);

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  opc;
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [16:0] imm;
    logic [31:0] exp;
    logic        dz;
    logic        il;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    // R1 register add/sub
    '{4'd1, 5'd1, 4'h0, 32'h5, 32'h7, 17'h0, 32'hC, 1'b0, 1'b0},
    '{4'd1, 5'd1, 4'h0, 32'hFFFFFFFF, 32'h1, 17'h0, 32'h0, 1'b0, 1'b0},
    '{4'd1, 5'd1, 4'h1, 32'h3, 32'h5, 17'h0, 32'hFFFFFFFE, 1'b0, 1'b0},
    // R2 immediate form, b_i holds a decoy
    '{4'd2, 5'd2, 4'h0, 32'hA, 32'hDEAD, 17'h1FFFE, 32'h8, 1'b0, 1'b0},
    '{4'd2, 5'd2, 4'h0, 32'h1, 32'hDEAD, 17'h0FFFF, 32'h10000, 1'b0, 1'b0},
    '{4'd2, 5'd2, 4'h4, 32'h12345678, 32'h0, 17'h10000, 32'h12340000, 1'b0, 1'b0},
    // R3 multiply
    '{4'd3, 5'd1, 4'h2, 32'hFFFFFFFD, 32'h7, 17'h0, 32'hFFFFFFEB, 1'b0, 1'b0},
    '{4'd3, 5'd1, 4'h2, 32'h10000, 32'h10000, 17'h0, 32'h0, 1'b0, 1'b0},
    // R4 divide
    '{4'd4, 5'd1, 4'h3, 32'hFFFFFFF9, 32'h2, 17'h0, 32'hFFFFFFFD, 1'b0, 1'b0},
    '{4'd4, 5'd1, 4'h3, 32'h7, 32'hFFFFFFFE, 17'h0, 32'hFFFFFFFD, 1'b0, 1'b0},
    '{4'd4, 5'd1, 4'h3, 32'h80000000, 32'hFFFFFFFF, 17'h0, 32'h80000000, 1'b0, 1'b0},
    // R5 divide by zero
    '{4'd5, 5'd1, 4'h3, 32'h5, 32'h0, 17'h0, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{4'd5, 5'd2, 4'h3, 32'h5, 32'h9, 17'h0, 32'hFFFFFFFF, 1'b1, 1'b0},
    // R6 logic
    '{4'd6, 5'd1, 4'h5, 32'hF0, 32'h0F, 17'h0, 32'hFF, 1'b0, 1'b0},
    '{4'd6, 5'd1, 4'h6, 32'hFF, 32'h0F, 17'h0, 32'hF0, 1'b0, 1'b0},
    // R7 logical shifts, count from low 5 bits
    '{4'd7, 5'd1, 4'h8, 32'h1, 32'h21, 17'h0, 32'h2, 1'b0, 1'b0},
    '{4'd7, 5'd2, 4'h8, 32'h1, 32'h0, 17'h1F, 32'h80000000, 1'b0, 1'b0},
    '{4'd7, 5'd1, 4'hA, 32'h80000000, 32'h4, 17'h0, 32'h08000000, 1'b0, 1'b0},
    // R8 arithmetic shift right
    '{4'd8, 5'd1, 4'hB, 32'h80000000, 32'h4, 17'h0, 32'hF8000000, 1'b0, 1'b0},
    '{4'd8, 5'd1, 4'hB, 32'h7FFFFFF0, 32'h4, 17'h0, 32'h07FFFFFF, 1'b0, 1'b0},
    // R9 rotate left
    '{4'd9, 5'd1, 4'h9, 32'h80000001, 32'h1, 17'h0, 32'h00000003, 1'b0, 1'b0},
    '{4'd9, 5'd1, 4'h9, 32'h12345678, 32'h0, 17'h0, 32'h12345678, 1'b0, 1'b0},
    '{4'd9, 5'd2, 4'h9, 32'h12345678, 32'h0, 17'h4, 32'h23456781, 1'b0, 1'b0},
    // R10 illegal codes
    '{4'd10, 5'd1, 4'h7, 32'h5, 32'h5, 17'h0, 32'h0, 1'b0, 1'b1},
    '{4'd10, 5'd1, 4'hF, 32'h5, 32'h5, 17'h0, 32'h0, 1'b0, 1'b1},
    '{4'd10, 5'd3, 4'h0, 32'h5, 32'h5, 17'h0, 32'h0, 1'b0, 1'b1},
    '{4'd10, 5'd1, 4'hC, 32'h5, 32'h0, 17'h0, 32'h0, 1'b0, 1'b1}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opc_i = v.opc; func_i = v.fn; a_i = v.a; b_i = v.b; imm_i = v.imm;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    // R11 reset state
    #12;
    check(11, result_o, 32'h0);
    check(11, {31'b0, div_zero_o | illegal_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check(int'(VECS[i].req), result_o, VECS[i].exp);
      check(int'(VECS[i].req), {30'b0, div_zero_o, illegal_o}, {30'b0, VECS[i].dz, VECS[i].il});
    end

    // R11 output holds until the sampling edge
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[2]);
    #2;
    check(11, result_o, 32'hC);
    @(negedge clk);
    check(11, result_o, 32'hFFFFFFFE);

    // R11 asynchronous reset clears a live result
    drive(VECS[11]);
    @(negedge clk);
    check(5, {31'b0, div_zero_o}, 32'h1);
    #2 rst_ni = 1'b0;
    #1;
    check(11, result_o, 32'h0);
    check(11, {31'b0, div_zero_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule